// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block is the receive side of a synchronous serial port. On every rising edge of its bit clock it samples one serial data bit. It groups the bits into words of `WORD_W` bits, most significant bit first. A word starts on a frame-sync pulse, and each complete word is moved into a holding register that carries a full flag and an overrun flag. The frame sync comes either from an input pin or from an internal generator, chosen by a select input.

Three modes are supported. In normal mode and in on-demand mode, every word begins with its own frame-sync pulse. In network mode, one pulse opens a frame of `SLOTS` time slots, and the slots follow each other with no gap. A receive-enable register decides whether a word reaches the holding register. The decision is made when the word's first bit arrives, so a word that is already in flight always lands in the register, even if the enable is cleared partway through it. In network mode, turning the enable off and then on again mid-frame suspends reception until the next frame begins. The internal frame-sync generator runs whatever the enable state is.

Top module: `srx_receiver`

## Requirements
- R1: After hardware reset, `rx_full`, `rx_overrun` and `fs_gen` are 0 and the enable register is cleared, so a framed word sent before any enable write is not captured.
- R2: A word begins at the edge where the selected frame sync is sampled high; that edge's `rx_data` is the MSB. On the edge that samples the `WORD_W`-th bit, `rx_word` takes the word and `rx_full` goes to 1.
- R3: A word whose first bit is sampled while the enable register is 0 is never transferred, and `rx_full` stays 0.
- R4: Clearing the enable while a word is being shifted in does not truncate it: the whole word is still transferred.
- R5: `mode` encodes 2'b00 normal, 2'b01 network, 2'b10 on-demand. In on-demand mode, as in normal mode, a word is captured only when the enable is set.
- R6: In network mode, the frame-sync pulse marks slot 0. Slots 1 to `SLOTS`-1 follow back to back, `WORD_W` bits each, with no frame sync. Each slot is transferred as its own word.
- R7: In network mode, if the enable is cleared and then set again within a frame, the word in progress completes, the remaining slots of that frame are dropped, and capture resumes at the next frame-sync pulse.
- R8: A write of 1 via `en_wr`/`en_val` sets the enable. Both `rst_n` low and a `soft_rst` pulse clear it, and it stays cleared until it is written again.
- R9: `fs_gen` is a one-cycle pulse. Its period is `WORD_W` cycles in normal and on-demand mode and `WORD_W`*`SLOTS` cycles in network mode, and it runs whatever the enable state is.
- R10: A cycle with `rd_strobe` high and no transfer clears `rx_full` and `rx_overrun` at that edge.
- R11: A transfer while `rx_full` is 1 and no read is made overwrites `rx_word` and sets `rx_overrun`.
- R12: In normal mode, a frame-sync pulse that arrives while a word is in progress is ignored.
- R13: With `fs_sel` = 1, the internal generator pulse replaces `fs_in` as the word-start marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset; clears the enable and the flags |
| en_wr | input | 1 | Write strobe for the enable register |
| en_val | input | 1 | Value written to the enable register |
| mode | input | 2 | 00 normal, 01 network, 10 on-demand |
| fs_sel | input | 1 | 1 selects the internal frame-sync pulse |
| fs_in | input | 1 | External frame-sync input |
| rx_data | input | 1 | Serial receive data |
| rd_strobe | input | 1 | Read of the holding register |
| rx_word | output | WORD_W | Holding register contents |
| rx_full | output | 1 | A word is waiting to be read |
| rx_overrun | output | 1 | A word arrived while the previous one was unread |
| fs_gen | output | 1 | Internal frame-sync pulse |

## Verification
The bench sends distinct bit patterns: alternating bits, walking ones, all ones and near-zero values. A bit that is shifted out of place or a word with its bit order reversed is therefore caught. The enable is cleared in the middle of a word, which separates a receiver that truncates the word from one that completes it. In network mode, a disable and re-enable within one frame separates suspending reception until the next frame from resuming at the very next slot. The generator period is measured while the receiver is disabled, in both period settings. An extra frame-sync pulse placed mid-word and two unread words in a row test that the word boundary holds and that the overrun path works.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    SRX_MODE_NORMAL = 2'b00,
    SRX_MODE_NET    = 2'b01,
    SRX_MODE_DEMAND = 2'b10,
    SRX_MODE_RSVD   = 2'b11
  } srx_mode_e;
endpackage

// File: rtl/srx_enable_ctl.sv
module srx_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic en_wr,
  input  logic en_val,
  input  logic net_mode,
  input  logic frame_start,
  output logic en_q,
  output logic suspend_q
);
  logic en_d;
  logic suspend_d;
  logic net_drop;

  // a disable write that lands while enabled, in network mode, holds off the frame
  assign net_drop = net_mode & en_wr & ~en_val & en_q;

  always_comb begin
    en_d = en_q;
    if (soft_rst)   en_d = 1'b0;
    else if (en_wr) en_d = en_val;
  end

  always_comb begin
    suspend_d = suspend_q;
    if (soft_rst || !net_mode) suspend_d = 1'b0;
    else if (net_drop)         suspend_d = 1'b1;
    else if (frame_start)      suspend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      suspend_q <= 1'b0;
    end else begin
      en_q      <= en_d;
      suspend_q <= suspend_d;
    end
  end
endmodule

// File: rtl/srx_fs_gen.sv
module srx_fs_gen #(
  parameter int WORD_W = 24,
  parameter int SLOTS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic net_mode,
  output logic fs_pulse
);
  localparam int PERIOD_MAX = WORD_W * SLOTS;
  localparam int PW         = (PERIOD_MAX > 1) ? $clog2(PERIOD_MAX) : 1;
  localparam logic [PW-1:0] LIM_NET  = PW'(PERIOD_MAX - 1);
  localparam logic [PW-1:0] LIM_WORD = PW'(WORD_W - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          pulse_d;
  logic [PW-1:0] limit;

  assign limit = net_mode ? LIM_NET : LIM_WORD;

  always_comb begin
    pulse_d = (cnt_q >= limit);
    cnt_d   = pulse_d ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      fs_pulse <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      fs_pulse <= pulse_d;
    end
  end
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int WORD_W = 24,
  parameter int SLOTS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_data,
  input  logic              fs,
  input  logic              net_mode,
  input  logic              en_q,
  input  logic              suspend_q,
  output logic              frame_start,
  output logic              word_start,
  output logic              armed_q,
  output logic              xfer,
  output logic [WORD_W-1:0] word_out
);
  localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [BW-1:0] LAST_BIT  = BW'(WORD_W - 1);
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

  logic              busy_q, busy_d;
  logic              chain_q, chain_d;
  logic              armed_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [SW-1:0]     slot_q, slot_d;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic              next_slot;
  logic              last_bit;
  logic              sr_en;

  assign frame_start = fs & ~busy_q;
  assign next_slot   = ~busy_q & chain_q & ~fs;
  assign word_start  = frame_start | next_slot;
  assign last_bit    = busy_q & (bit_q == LAST_BIT);
  assign xfer        = last_bit & armed_q;
  assign word_out    = {sr_q[WORD_W-2:0], rx_data};
  assign sr_en       = busy_q | word_start;

  always_comb begin
    busy_d  = busy_q;
    chain_d = chain_q;
    armed_d = armed_q;
    bit_d   = bit_q;
    slot_d  = slot_q;
    if (word_start) begin
      busy_d  = 1'b1;
      chain_d = 1'b0;
      bit_d   = BW'(1);
      slot_d  = frame_start ? '0 : slot_q + 1'b1;
      // capture permission is fixed by the first bit of the word
      armed_d = en_q & (frame_start | ~suspend_q);
    end else if (last_bit) begin
      busy_d  = 1'b0;
      bit_d   = '0;
      chain_d = net_mode & (slot_q != LAST_SLOT);
    end else if (busy_q) begin
      bit_d = bit_q + 1'b1;
    end
  end

  always_comb begin
    sr_d = sr_q;
    if (sr_en) sr_d = {sr_q[WORD_W-2:0], rx_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      chain_q <= 1'b0;
      armed_q <= 1'b0;
      bit_q   <= '0;
      slot_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      chain_q <= chain_d;
      armed_q <= armed_d;
      bit_q   <= bit_d;
      slot_q  <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end
endmodule

// File: rtl/srx_holding.sv
module srx_holding #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              xfer,
  input  logic [WORD_W-1:0] word_in,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_full,
  output logic              rx_overrun
);
  logic full_d, ovr_d;

  always_comb begin
    full_d = rx_full;
    ovr_d  = rx_overrun;
    if (soft_rst) begin
      full_d = 1'b0;
      ovr_d  = 1'b0;
    end else if (xfer) begin
      full_d = 1'b1;
      if (rx_full && !rd_strobe) ovr_d = 1'b1;
    end else if (rd_strobe) begin
      full_d = 1'b0;
      ovr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full    <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      rx_full    <= full_d;
      rx_overrun <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rx_word <= '0;
    else if (xfer) rx_word <= word_in;
  end
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
  import srx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int SLOTS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              en_wr,
  input  logic              en_val,
  input  logic [1:0]        mode,
  input  logic              fs_sel,
  input  logic              fs_in,
  input  logic              rx_data,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_full,
  output logic              rx_overrun,
  output logic              fs_gen
);
  srx_mode_e         mode_e;
  logic              net_mode;
  logic              fs_sel_q;
  logic              en_q;
  logic              suspend_q;
  logic              frame_start;
  logic              sh_start;
  logic              sh_armed;
  logic              sh_xfer;
  logic [WORD_W-1:0] sh_word;

  assign mode_e   = srx_mode_e'(mode);
  assign net_mode = (mode_e == SRX_MODE_NET);
  assign fs_sel_q = fs_sel ? fs_gen : fs_in;

  srx_enable_ctl u_en (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .en_wr       (en_wr),
    .en_val      (en_val),
    .net_mode    (net_mode),
    .frame_start (frame_start),
    .en_q        (en_q),
    .suspend_q   (suspend_q)
  );

  srx_fs_gen #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_fsg (
    .clk      (clk),
    .rst_n    (rst_n),
    .net_mode (net_mode),
    .fs_pulse (fs_gen)
  );

  srx_shifter #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_sh (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_data     (rx_data),
    .fs          (fs_sel_q),
    .net_mode    (net_mode),
    .en_q        (en_q),
    .suspend_q   (suspend_q),
    .frame_start (frame_start),
    .word_start  (sh_start),
    .armed_q     (sh_armed),
    .xfer        (sh_xfer),
    .word_out    (sh_word)
  );

  srx_holding #(.WORD_W(WORD_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .xfer       (sh_xfer),
    .word_in    (sh_word),
    .rd_strobe  (rd_strobe),
    .rx_word    (rx_word),
    .rx_full    (rx_full),
    .rx_overrun (rx_overrun)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic rd_strobe,
  input logic rx_full,
  input logic rx_overrun,
  input logic fs_gen,
  input logic en_q,
  input logic word_start,
  input logic armed_q,
  input logic xfer
);
  a_r8_soft_reset_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !en_q);

  a_r9_fs_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fs_gen |=> !fs_gen);

  a_r2_transfer_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !soft_rst) |=> rx_full);

  a_r10_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !xfer) |=> (!rx_full && !rx_overrun));

  a_r11_overrun_on_unread: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && rx_full && !rd_strobe && !soft_rst) |=> rx_overrun);

  a_r3_start_while_disabled_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (word_start && !en_q) |=> !armed_q);
endmodule

bind srx_receiver srx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .rd_strobe  (rd_strobe),
  .rx_full    (rx_full),
  .rx_overrun (rx_overrun),
  .fs_gen     (fs_gen),
  .en_q       (en_q),
  .word_start (sh_start),
  .armed_q    (sh_armed),
  .xfer       (sh_xfer)
);

// File: tb/srx_receiver_test.sv
module srx_receiver_test;
  localparam int W = 8;
  localparam int S = 4;

  logic         clk = 1'b0;
  logic         rst_n, soft_rst, en_wr, en_val, fs_sel, fs_in, rx_data;
  logic [1:0]   mode;
  logic         mon_rd = 1'b0, man_rd;
  logic         rd_strobe;
  logic [W-1:0] rx_word;
  logic         rx_full, rx_overrun, fs_gen;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit auto_rd = 1'b0;
  bit done    = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  assign rd_strobe = mon_rd | man_rd;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  srx_receiver #(.WORD_W(W), .SLOTS(S)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .en_wr(en_wr), .en_val(en_val),
    .mode(mode), .fs_sel(fs_sel), .fs_in(fs_in), .rx_data(rx_data),
    .rd_strobe(rd_strobe), .rx_word(rx_word), .rx_full(rx_full),
    .rx_overrun(rx_overrun), .fs_gen(fs_gen)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a word is waiting
  always @(negedge clk) begin
    if (auto_rd && rst_n) begin
      if (rx_full) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected word", rx_word, 0);
        end else begin
          automatic logic [W-1:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(rx_word == e, t, "received word", rx_word, e);
        end
        mon_rd = 1'b1;
      end else begin
        mon_rd = 1'b0;
      end
    end else begin
      mon_rd = 1'b0;
    end
  end

  // driver: called at a negedge; drives one bit per cycle
  task automatic send_word(input logic [W-1:0] d, input bit fs, input bit expect_it,
                           input string tag, input int op1_at, input bit op1_v,
                           input int op2_at, input bit op2_v, input int fs_extra);
    for (int i = 0; i < W; i++) begin
      rx_data = d[W-1-i];
      fs_in   = (i == 0 && fs) || (i == fs_extra);
      en_wr   = (i == op1_at) || (i == op2_at);
      en_val  = (i == op1_at) ? op1_v : op2_v;
      if (i == 0 && expect_it) begin
        exp_q.push_back(d);
        tag_q.push_back(tag);
      end
      @(negedge clk);
    end
    fs_in = 1'b0;
    en_wr = 1'b0;
    rx_data = 1'b0;
  endtask

  task automatic plain(input logic [W-1:0] d, input bit fs, input bit expect_it, input string tag);
    send_word(d, fs, expect_it, tag, -1, 1'b0, -1, 1'b0, -1);
  endtask

  task automatic en_write(input bit v);
    en_wr = 1'b1; en_val = v;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_period(output int p);
    int t0;
    @(negedge clk);
    while (!fs_gen) @(negedge clk);
    t0 = cyc;
    @(negedge clk);
    while (!fs_gen) @(negedge clk);
    p = cyc - t0;
  endtask

  initial begin
    int p;
    rst_n = 1'b0; soft_rst = 1'b0; en_wr = 1'b0; en_val = 1'b0; mode = 2'b00;
    fs_sel = 1'b0; fs_in = 1'b0; rx_data = 1'b0; man_rd = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rx_full == 1'b0, "R1", "full after reset", rx_full, 0);
    check(rx_overrun == 1'b0, "R1", "overrun after reset", rx_overrun, 0);
    check(fs_gen == 1'b0, "R1", "fs_gen after reset", fs_gen, 0);
    rst_n = 1'b1;
    idle(1);
    auto_rd = 1'b1;
    plain(8'hA5, 1'b1, 1'b0, "R1");   // enable cleared: dropped
    idle(2);
    check(rx_full == 1'b0, "R1", "no capture before enable", rx_full, 0);

    // R2 basic normal-mode words, R12 extra fs ignored mid-word
    en_write(1'b1);
    plain(8'hA5, 1'b1, 1'b1, "R2");
    plain(8'h01, 1'b1, 1'b1, "R2");
    plain(8'h80, 1'b1, 1'b1, "R2");
    send_word(8'h3C, 1'b1, 1'b1, "R12", -1, 1'b0, -1, 1'b0, 4);
    plain(8'hFF, 1'b1, 1'b1, "R12");
    idle(3);

    // R4 disable mid-word keeps word; R3 next word dropped
    send_word(8'h96, 1'b1, 1'b1, "R4", 3, 1'b0, -1, 1'b0, -1);
    plain(8'h5A, 1'b1, 1'b0, "R3");
    idle(3);
    check(rx_full == 1'b0, "R3", "full after disabled word", rx_full, 0);

    // R5 on-demand mode needs enable
    mode = 2'b10;
    plain(8'h42, 1'b1, 1'b0, "R5");
    idle(3);
    check(rx_full == 1'b0, "R5", "on-demand while disabled", rx_full, 0);
    en_write(1'b1);
    plain(8'h24, 1'b1, 1'b1, "R5");
    idle(3);

    // R6 network frame; R7 toggle mid slot1 suspends until next frame
    mode = 2'b01;
    idle(2);
    plain(8'h11, 1'b1, 1'b1, "R6");
    send_word(8'h22, 1'b0, 1'b1, "R7", 2, 1'b0, 5, 1'b1, -1);
    plain(8'h33, 1'b0, 1'b0, "R7");
    plain(8'h44, 1'b0, 1'b0, "R7");
    plain(8'h55, 1'b1, 1'b1, "R7");
    plain(8'h66, 1'b0, 1'b1, "R6");
    plain(8'h77, 1'b0, 1'b1, "R6");
    plain(8'h88, 1'b0, 1'b1, "R6");
    idle(3);
    mode = 2'b00;

    // R8 soft reset clears enable
    soft_rst = 1'b1;
    idle(1);
    soft_rst = 1'b0;
    plain(8'hC3, 1'b1, 1'b0, "R8");
    idle(3);
    check(rx_full == 1'b0, "R8", "capture after soft reset", rx_full, 0);
    check(exp_q.size() == 0, "R2", "words still pending", exp_q.size(), 0);

    // R11 overrun, R10 read clears
    en_write(1'b1);
    auto_rd = 1'b0;
    idle(1);
    plain(8'h12, 1'b1, 1'b0, "R11");
    plain(8'h34, 1'b1, 1'b0, "R11");
    check(rx_full == 1'b1, "R11", "full after two words", rx_full, 1);
    check(rx_overrun == 1'b1, "R11", "overrun flag", rx_overrun, 1);
    check(rx_word == 8'h34, "R11", "overwritten word", rx_word, 8'h34);
    man_rd = 1'b1;
    idle(1);
    man_rd = 1'b0;
    check(rx_full == 1'b0, "R10", "full after read", rx_full, 0);
    check(rx_overrun == 1'b0, "R10", "overrun after read", rx_overrun, 0);
    auto_rd = 1'b1;

    // R13 internal frame sync drives word alignment
    fs_sel = 1'b1;
    while (!fs_gen) @(negedge clk);
    plain(8'hE7, 1'b0, 1'b1, "R13");
    plain(8'h18, 1'b0, 1'b1, "R13");
    fs_sel = 1'b0;
    idle(4);
    check(exp_q.size() == 0, "R13", "words still pending", exp_q.size(), 0);

    // R9 generator runs while disabled
    en_write(1'b0);
    measure_period(p);
    measure_period(p);
    check(p == W, "R9", "period normal", p, W);
    mode = 2'b01;
    measure_period(p);
    measure_period(p);
    check(p == W * S, "R9", "period network while disabled", p, W * S);
    check(rx_full == 1'b0, "R9", "no capture while disabled", rx_full, 0);
    mode = 2'b00;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule